// File: doc/BRIEF.md
# Interrupt Status Aggregator

This unit gathers the interrupt sources of a two-wire bus controller into one 32-bit raw status word, gates it with a software-owned enable mask, and drives a single interrupt request line. Two kinds of source share the word. The low seven bits are FIFO level flags. They are shown exactly as the FIFO logic drives them and cannot be cleared. The other defined bits are event flags. Each one latches on a one-cycle pulse from its source and stays set until software writes a one to it through the clear strobe.

The register decode lives outside this unit. It presents a write data word together with two strobes: one that loads the mask and one that acknowledges events. Read paths take the raw, mask and masked words straight from the output ports. Any bit outside the defined layout reads as zero in every word and cannot be stored.

Top module: `irq_status_unit`

## Requirements
- R1: After reset is asserted, every event flag and every mask bit is zero and `irq_o` is low.
- R2: Bits 6:0 of `raw_o` equal `fifo_lvl_i` in the same cycle. The bit assignments are 0 transmit empty, 1 transmit nearly empty, 2 transmit full, 3 transmit overrun, 4 receive empty, 5 receive nearly full and 6 receive full. A clear write never changes these bits.
- R3: A one on `evt_i` at an event position sets that `raw_o` bit from the next clock edge on. The bit then holds until it is cleared. The event positions are 16, 17 and 18 for target-side requests, 19 for master done, 20 for target done, 24 for arbitration lost, 25 for bus error and 28 for master done without stop.
- R4: When `clr_we_i` is high, each one in `wdata_i` at an event position clears that flag at the next edge. Zeros in `wdata_i` leave their flags unchanged.
- R5: If an event pulse and a clear of the same bit arrive in the same cycle, the flag is set after the edge.
- R6: When `mask_we_i` is high, the mask loads `wdata_i` AND 0x131F007F at the next edge. Otherwise the mask holds its value.
- R7: `masked_o` equals `raw_o` AND `mask_o` in every cycle.
- R8: `irq_o` is the OR of all `masked_o` bits, registered once, so it follows `masked_o` with a delay of one clock.
- R9: Every bit outside the pattern 0x131F007F reads as zero in `raw_o` and `mask_o`. This includes bits 29 to 31. Pulses on `evt_i` at those positions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_lvl_i | input | 7 | Live FIFO level flags |
| evt_i | input | 32 | One-cycle event pulses at their status bit positions |
| wdata_i | input | 32 | Write data for the mask and clear strobes |
| mask_we_i | input | 1 | Load the mask from `wdata_i` |
| clr_we_i | input | 1 | Clear the event flags where `wdata_i` is one |
| raw_o | output | 32 | Raw status word |
| mask_o | output | 32 | Current mask |
| masked_o | output | 32 | Raw status AND mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two functions can collide in one cycle. An event source may fire in the same cycle that software acknowledges the same bit. A mask write may also land in the cycle in which the request register samples the masked word. The directed part of the bench pulses bit 24 together with a clear of bit 24 and expects the flag to stay set. The random part drives event pulses, clear strobes and mask writes independently each cycle, so both kinds of collision occur many times. A reference model in the bench judges each one from the pre-edge values: it sets a flag if it was pulsed, and it forms the request from the old mask.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned LVL_W  = 7;
  localparam logic [STAT_W-1:0] LEVEL_MAP  = 32'h0000_007F;
  localparam logic [STAT_W-1:0] STICKY_MAP = 32'h131F_0000;
  localparam logic [STAT_W-1:0] WRITE_MAP  = LEVEL_MAP | STICKY_MAP;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int unsigned           W   = 32,
  parameter logic [W-1:0]          MAP = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] evt_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q, flag_d;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (MAP[b]) begin : g_sticky
      // set beats clear
      assign flag_d[b] = evt_i[b] | (flag_q[b] & ~(clr_we_i & wdata_i[b]));
    end else begin : g_none
      assign flag_d[b] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  logic unused_evt;
  assign unused_evt = ^(evt_i & ~MAP) ^ ^(wdata_i & ~MAP);
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned  W   = 32,
  parameter logic [W-1:0] MAP = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i & MAP;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned  W     = 32,
  parameter int unsigned  LW    = 7,
  parameter logic [W-1:0] L_MAP = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] lvl_i,
  input  logic [W-1:0]  sticky_i,
  input  logic [W-1:0]  mask_i,
  output logic [W-1:0]  raw_o,
  output logic [W-1:0]  masked_o,
  output logic          irq_o
);
  localparam int unsigned PAD_W = W - LW;

  logic [W-1:0] lvl_ext;
  logic         irq_q;

  assign lvl_ext  = {{PAD_W{1'b0}}, lvl_i} & L_MAP;
  assign raw_o    = lvl_ext | sticky_i;
  assign masked_o = raw_o & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |masked_o;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_stat_pkg::*;
#(
  parameter int unsigned           W          = STAT_W,
  parameter int unsigned           LW         = LVL_W,
  parameter logic [STAT_W-1:0]     L_MAP      = LEVEL_MAP,
  parameter logic [STAT_W-1:0]     S_MAP      = STICKY_MAP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LW-1:0] fifo_lvl_i,
  input  logic [W-1:0]  evt_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          mask_we_i,
  input  logic          clr_we_i,
  output logic [W-1:0]  raw_o,
  output logic [W-1:0]  mask_o,
  output logic [W-1:0]  masked_o,
  output logic          irq_o
);
  localparam logic [W-1:0] WR_MAP = L_MAP | S_MAP;

  logic [W-1:0] sticky;

  irq_sticky_bank #(.W(W), .MAP(S_MAP)) u_sticky (
    .clk_i, .rst_ni,
    .evt_i, .clr_we_i, .wdata_i,
    .flag_o (sticky)
  );

  irq_mask_reg #(.W(W), .MAP(WR_MAP)) u_mask (
    .clk_i, .rst_ni,
    .we_i    (mask_we_i),
    .wdata_i,
    .mask_o
  );

  irq_combine #(.W(W), .LW(LW), .L_MAP(L_MAP)) u_comb (
    .clk_i, .rst_ni,
    .lvl_i    (fifo_lvl_i),
    .sticky_i (sticky),
    .mask_i   (mask_o),
    .raw_o,
    .masked_o,
    .irq_o
  );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk
  import irq_stat_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LVL_W-1:0]  fifo_lvl_i,
  input logic [STAT_W-1:0] evt_i,
  input logic [STAT_W-1:0] wdata_i,
  input logic              mask_we_i,
  input logic              clr_we_i,
  input logic [STAT_W-1:0] raw_o,
  input logic [STAT_W-1:0] mask_o,
  input logic [STAT_W-1:0] masked_o,
  input logic              irq_o
);
  assert_level_live_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    raw_o[LVL_W-1:0] == fifo_lvl_i);

  assert_event_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i & STICKY_MAP) != '0 |=>
      (raw_o & $past(evt_i & STICKY_MAP)) == $past(evt_i & STICKY_MAP));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> (raw_o & $past(wdata_i & ~evt_i & STICKY_MAP)) == '0);

  assert_event_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && (evt_i & wdata_i & STICKY_MAP) != '0) |=>
      (raw_o & $past(evt_i & wdata_i & STICKY_MAP)) == $past(evt_i & wdata_i & STICKY_MAP));

  assert_mask_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_o == ($past(wdata_i) & WRITE_MAP));

  assert_mask_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(mask_o));

  assert_masked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_o == (raw_o & mask_o));

  assert_irq_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|masked_o));

  assert_reserved_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((raw_o | mask_o) & ~WRITE_MAP) == '0);
endmodule

bind irq_status_unit irq_status_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fifo_lvl_i (fifo_lvl_i),
  .evt_i      (evt_i),
  .wdata_i    (wdata_i),
  .mask_we_i  (mask_we_i),
  .clr_we_i   (clr_we_i),
  .raw_o      (raw_o),
  .mask_o     (mask_o),
  .masked_o   (masked_o),
  .irq_o      (irq_o)
);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;
  localparam logic [31:0] LV = 32'h0000_007F;
  localparam logic [31:0] ST = 32'h131F_0000;
  localparam logic [31:0] WR = 32'h131F_007F;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  fifo_lvl_i = '0;
  logic [31:0] evt_i = '0, wdata_i = '0;
  logic        mask_we_i = 1'b0, clr_we_i = 1'b0;
  logic [31:0] raw_o, mask_o, masked_o;
  logic        irq_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] exp_sticky = '0, exp_mask = '0;
  logic        exp_irq = 1'b0;

  always #4 clk_i = ~clk_i;

  irq_status_unit uut (.*);

  function automatic logic [31:0] model_raw(logic [31:0] s, logic [6:0] l);
    return ({25'd0, l} & LV) | (s & ST);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] l, input logic [31:0] e,
                      input logic mwe, input logic cwe, input logic [31:0] wd);
    logic [31:0] r;
    fifo_lvl_i = l; evt_i = e; mask_we_i = mwe; clr_we_i = cwe; wdata_i = wd;
    #1;
    r = model_raw(exp_sticky, l);
    chk("R2 level bits", raw_o & LV, {25'd0, l});
    chk("R3 event flags", raw_o & ST, exp_sticky);
    chk("R9 reserved", (raw_o | mask_o) & ~WR, 32'd0);
    chk("R6 mask", mask_o, exp_mask);
    chk("R7 masked", masked_o, r & exp_mask);
    chk("R8 irq", {31'd0, irq_o}, {31'd0, exp_irq});
    @(posedge clk_i);
    exp_irq    = |(r & exp_mask);
    exp_sticky = ((e & ST) | (exp_sticky & ~(cwe ? wd : 32'd0))) & ST;
    if (mwe) exp_mask = wd & WR;
    @(negedge clk_i);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    evt_i = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 flags", raw_o & ~LV, 32'd0);
    chk("R1 mask", mask_o, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    evt_i = '0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3 set and hold, R4 zero write ignored, then clear
    step(7'h00, 32'h0008_0000, 0, 0, 0);
    step(7'h00, 0, 0, 1, 32'h0000_0000);
    step(7'h00, 0, 0, 0, 0);
    chk("R4 zero clear", raw_o & 32'h0008_0000, 32'h0008_0000);
    step(7'h00, 0, 0, 1, 32'h0008_0000);
    step(7'h00, 0, 0, 0, 0);
    chk("R4 one clear", raw_o & 32'h0008_0000, 32'd0);

    // R5 event beats clear on bit 24
    step(7'h00, 32'h0100_0000, 0, 1, 32'h0100_0000);
    step(7'h00, 0, 0, 0, 0);
    chk("R5 event wins", raw_o & 32'h0100_0000, 32'h0100_0000);

    // R2 clear of all ones leaves level bits
    step(7'h7F, 0, 0, 1, 32'hFFFF_FFFF);
    step(7'h7F, 0, 0, 0, 0);
    chk("R2 clear ignored", raw_o & LV, LV);

    // R9 events and mask writes on reserved bits
    step(7'h00, 32'hECE0_FF80, 1, 0, 32'hFFFF_FFFF);
    step(7'h00, 0, 0, 0, 0);
    chk("R9 raw reserved", raw_o & ~WR, 32'd0);
    chk("R6 mask writable", mask_o, WR);

    // R8 irq from a single masked level bit
    step(7'h00, 0, 1, 1, 32'h0000_0004);
    step(7'h04, 0, 0, 0, 0);
    step(7'h00, 0, 0, 0, 0);
    step(7'h00, 0, 0, 0, 0);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] e, wd;
      e  = ($urandom % 4 == 0) ? $urandom : 32'd0;
      wd = $urandom;
      step(7'($urandom), e, ($urandom % 6 == 0), ($urandom % 3 == 0), wd);
    end
    step(7'h00, 0, 0, 0, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule